// File: doc/BRIEF.md
# Per-Hart Software Interrupt Unit

This block gives each hart of a multi-core cluster one 32-bit memory-mapped word for raising an inter-processor software interrupt. Each hart also gets one level output that drives its software-interrupt pending input. Another core posts an interrupt by writing the target hart's word with bit 0 set. Hart `h` owns the word at byte offset `4*h` from the block base.

A mode parameter picks one of two behaviours. In machine mode the word is a plain level register: bit 0 sets or clears the line, and a read returns the line's state. In supervisor mode the word is a write-only trigger. Writing 1 raises the line, writing 0 has no effect, and every read returns zero. The line is cleared instead through a per-hart acknowledge input, which the receiving core drives when it takes the interrupt.

The bus is a simple 32-bit register port. A request lasts one cycle. Read data comes back with a one-cycle valid strobe on the following cycle.

Top module: `hart_swi_unit`

## Requirements
- R1: After reset every pending output is 0 and the read-valid strobe is 0.
- R2: A write with bit 0 = 1 to byte offset 4*h (h < NUM_HARTS) sets `swi_pend[h]` on the next clock edge and leaves every other hart's line unchanged. This holds in both modes.
- R3: In machine mode, a write with bit 0 = 0 to hart h's word clears `swi_pend[h]` on the next edge. Bits 31:1 of the write data are ignored.
- R4: In machine mode, a read of hart h's word returns `swi_pend[h]` in bit 0 as it was when the request was taken. Bits 31:1 read as zero.
- R5: In supervisor mode, a write with bit 0 = 0 leaves the hart's line unchanged.
- R6: In supervisor mode, every read returns zero, whatever the pending state.
- R7: In supervisor mode, `swi_ack[h]` = 1 clears `swi_pend[h]` on the next edge. If a set write to the same hart arrives in the same cycle, the set wins and the line is 1.
- R8: In machine mode, the `swi_ack` inputs have no effect on any line.
- R9: An access is invalid if address bits 1:0 are not 00, or if the word index (address >> 2) is NUM_HARTS or more. An invalid write changes no line, and an invalid read returns zero.
- R10: `bus_rvalid` is 1 exactly in the cycle after a read request. A write request never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_wdata | input | DATA_W | Write data; only bit 0 is used |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rvalid` is 1 |
| bus_rvalid | output | 1 | Read response strobe |
| swi_ack | input | NUM_HARTS | Per-hart clear, used in supervisor mode only |
| swi_pend | output | NUM_HARTS | Per-hart software interrupt pending line |

## Verification
The bench drives one machine-mode and one supervisor-mode instance from the same bus. Both instances are compared every cycle against a behavioural model. The model flags a supervisor unit that clears on a written zero, or lets an acknowledge beat a simultaneous set: in either case the line drops when it should stay high. It also flags a machine unit that honours the acknowledge input and loses interrupts. Misaligned offsets and indices just past the last hart are aimed at, because an unmasked decoder would alias them onto real harts and set lines nobody wrote. Read returns are checked against the state before the request, so a design that returns post-write or stale data, or leaks upper bits, gives a mismatch.

// File: rtl/swi_pkg.sv
package swi_pkg;
   typedef enum logic {
      SWI_MACHINE    = 1'b0,
      SWI_SUPERVISOR = 1'b1
   } swi_mode_e;

   localparam int SWI_WORD_BYTES = 4;
endpackage

// File: rtl/swi_addr_dec.sv
module swi_addr_dec #(
   parameter int ADDR_W    = 12,
   parameter int NUM_HARTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wbit,
   output logic [NUM_HARTS-1:0] wr_one,
   output logic [NUM_HARTS-1:0] wr_zero,
   output logic [NUM_HARTS-1:0] rd_sel,
   output logic                 rd_req
);
   localparam int IDX_W = ADDR_W - 2;

   logic                 word_ok;
   logic [NUM_HARTS-1:0] hit;

   assign word_ok = req && (addr[1:0] == 2'b00);
   assign rd_req  = req && !wr;

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hit
      assign hit[h]     = word_ok && (addr[ADDR_W-1:2] == IDX_W'(h));
      assign wr_one[h]  = hit[h] && wr && wbit;
      assign wr_zero[h] = hit[h] && wr && !wbit;
      assign rd_sel[h]  = hit[h] && !wr;
   end

   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_one | wr_zero | rd_sel));
   p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && addr[1:0] != 2'b00) |-> ((wr_one | wr_zero | rd_sel) == '0));
endmodule

// File: rtl/swi_pend_cell.sv
module swi_pend_cell
   import swi_pkg::*;
#(
   parameter swi_mode_e MODE = SWI_MACHINE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_one,
   input  logic wr_zero,
   input  logic ack,
   output logic pend
);
   if (MODE == SWI_MACHINE) begin : g_level
      logic unused_ack;
      assign unused_ack = ack;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pend <= 1'b0;
         else if (wr_one)  pend <= 1'b1;
         else if (wr_zero) pend <= 1'b0;
      end

      p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_one |=> pend);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         wr_zero |=> !pend);
      p_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_one && !wr_zero) |=> $stable(pend));
   end else begin : g_trigger
      logic unused_zero;
      assign unused_zero = wr_zero;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend <= 1'b0;
         else if (wr_one) pend <= 1'b1;
         else if (ack)    pend <= 1'b0;
      end

      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         wr_one |=> pend);
      p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (ack && !wr_one) |=> !pend);
      p_zero_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_one && !ack) |=> $stable(pend));
   end
endmodule

// File: rtl/swi_rd_port.sv
module swi_rd_port
   import swi_pkg::*;
#(
   parameter int        NUM_HARTS = 4,
   parameter int        DATA_W    = 32,
   parameter swi_mode_e MODE      = SWI_MACHINE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_req,
   input  logic [NUM_HARTS-1:0] rd_sel,
   input  logic [NUM_HARTS-1:0] pend_vec,
   output logic                 rvalid,
   output logic [DATA_W-1:0]    rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= rd_req;
   end

   if (MODE == SWI_MACHINE) begin : g_readable
      logic rbit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rbit_q <= 1'b0;
         else        rbit_q <= rd_req && |(rd_sel & pend_vec);
      end
      assign rdata = {{(DATA_W-1){1'b0}}, rbit_q};
   end else begin : g_blind
      logic unused_rd;
      assign unused_rd = ^{rd_sel, pend_vec};
      assign rdata     = '0;

      p_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         rvalid |-> (rdata == '0));
   end

   p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rvalid);
   p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rvalid);
   p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> (rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/hart_swi_unit.sv
module hart_swi_unit
   import swi_pkg::*;
#(
   parameter int        NUM_HARTS = 4,
   parameter int        ADDR_W    = 12,
   parameter int        DATA_W    = 32,
   parameter swi_mode_e MODE      = SWI_MACHINE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_req,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 bus_rvalid,
   input  logic [NUM_HARTS-1:0] swi_ack,
   output logic [NUM_HARTS-1:0] swi_pend
);
   localparam int SPAN_BYTES = NUM_HARTS * SWI_WORD_BYTES;

   if (DATA_W != 32) begin : g_bad_width
      $error("hart_swi_unit: DATA_W must be 32");
   end
   if (NUM_HARTS < 1) begin : g_bad_count
      $error("hart_swi_unit: NUM_HARTS must be at least 1");
   end
   if (SPAN_BYTES > (2 ** ADDR_W)) begin : g_bad_span
      $error("hart_swi_unit: ADDR_W too small for NUM_HARTS words");
   end

   logic [NUM_HARTS-1:0] wr_one;
   logic [NUM_HARTS-1:0] wr_zero;
   logic [NUM_HARTS-1:0] rd_sel;
   logic                 rd_req;
   logic                 unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:1];

   swi_addr_dec #(
      .ADDR_W    (ADDR_W),
      .NUM_HARTS (NUM_HARTS)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (bus_req),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wbit    (bus_wdata[0]),
      .wr_one  (wr_one),
      .wr_zero (wr_zero),
      .rd_sel  (rd_sel),
      .rd_req  (rd_req)
   );

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      swi_pend_cell #(
         .MODE (MODE)
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_one  (wr_one[h]),
         .wr_zero (wr_zero[h]),
         .ack     (swi_ack[h]),
         .pend    (swi_pend[h])
      );
   end

   swi_rd_port #(
      .NUM_HARTS (NUM_HARTS),
      .DATA_W    (DATA_W),
      .MODE      (MODE)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .rd_sel   (rd_sel),
      .pend_vec (swi_pend),
      .rvalid   (bus_rvalid),
      .rdata    (bus_rdata)
   );

   p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (swi_pend == '0 && !bus_rvalid));
endmodule

// File: tb/hart_swi_unit_tb_top.sv
module hart_swi_unit_tb_top;
   localparam int N  = 4;
   localparam int AW = 12;
   localparam int DW = 32;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          req   = 1'b0;
   logic          wr    = 1'b0;
   logic [AW-1:0] addr  = '0;
   logic [DW-1:0] wdata = '0;
   logic [N-1:0]  ack_m = '0;
   logic [N-1:0]  ack_s = '0;

   logic [DW-1:0] rdata_m, rdata_s;
   logic          rv_m, rv_s;
   logic [N-1:0]  pend_m, pend_s;

   logic [N-1:0]  mdl_m = '0;
   logic [N-1:0]  mdl_s = '0;
   logic          mdl_rv = 1'b0;
   logic          mdl_rbit = 1'b0;

   int    errors = 0;
   int    checks = 0;
   string tag    = "R1";

   always #4 clk = ~clk;

   hart_swi_unit #(
      .NUM_HARTS (N), .ADDR_W (AW), .DATA_W (DW), .MODE (swi_pkg::SWI_MACHINE)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .bus_req (req), .bus_wr (wr),
      .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata_m),
      .bus_rvalid (rv_m), .swi_ack (ack_m), .swi_pend (pend_m)
   );

   hart_swi_unit #(
      .NUM_HARTS (N), .ADDR_W (AW), .DATA_W (DW), .MODE (swi_pkg::SWI_SUPERVISOR)
   ) dut_s_i (
      .clk (clk), .rst_n (rst_n), .bus_req (req), .bus_wr (wr),
      .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata_s),
      .bus_rvalid (rv_s), .swi_ack (ack_s), .swi_pend (pend_s)
   );

   // Behavioural reference model, advanced at each rising edge.
   always @(posedge clk) begin : model
      int idx;
      bit ok;
      if (!rst_n) begin
         mdl_m = '0; mdl_s = '0; mdl_rv = 1'b0; mdl_rbit = 1'b0;
      end else begin
         idx      = int'(addr) / 4;
         ok       = req && (addr % 4 == 0) && (idx < N);
         mdl_rv   = req && !wr;
         mdl_rbit = (ok && !wr) ? mdl_m[idx] : 1'b0;
         if (ok && wr) mdl_m[idx] = wdata[0];
         for (int h = 0; h < N; h++) begin
            if (ok && wr && idx == h && wdata[0]) mdl_s[h] = 1'b1;
            else if (ack_s[h])                    mdl_s[h] = 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Compare every cycle on the falling edge, away from the active edge.
   always @(negedge clk) begin
      check(pend_m === mdl_m, "machine pending lines", 64'(pend_m), 64'(mdl_m));
      check(pend_s === mdl_s, "supervisor pending lines", 64'(pend_s), 64'(mdl_s));
      check(rv_m === mdl_rv, "machine read valid", 64'(rv_m), 64'(mdl_rv));
      check(rv_s === mdl_rv, "supervisor read valid", 64'(rv_s), 64'(mdl_rv));
      if (mdl_rv) begin
         check(rdata_m === {{(DW-1){1'b0}}, mdl_rbit}, "machine read data",
               64'(rdata_m), 64'(mdl_rbit));
         check(rdata_s === '0, "supervisor read data", 64'(rdata_s), 64'd0);
      end
   end

   task automatic op(input logic r, input logic w, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [N-1:0] am,
                     input logic [N-1:0] as);
      req = r; wr = w; addr = a; wdata = d; ack_m = am; ack_s = as;
      @(negedge clk);
      req = 1'b0; wr = 1'b0; ack_m = '0; ack_s = '0;
   endtask

   task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d);
      op(1'b1, 1'b1, a, d, '0, '0);
   endtask

   task automatic rd_op(input logic [AW-1:0] a);
      op(1'b1, 1'b0, a, '0, '0, '0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(1'b0, 1'b0, '0, '0, '0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      check(pend_m === '0 && pend_s === '0, "lines in reset", 64'({pend_m, pend_s}), 64'd0);
      rst_n = 1'b1;
      idle(2);
      tag = "R2";
      wr_op(12'h008, 32'h1);
      idle(1);
      wr_op(12'h000, 32'hFFFF_FFFF);
      idle(1);
      tag = "R4";
      rd_op(12'h008);
      rd_op(12'h004);
      rd_op(12'h000);
      idle(1);
      tag = "R3";
      wr_op(12'h008, 32'h0000_0002);
      rd_op(12'h008);
      idle(1);
      tag = "R5";
      wr_op(12'h000, 32'h0);
      rd_op(12'h000);
      idle(1);
      tag = "R6";
      rd_op(12'h000);
      rd_op(12'h008);
      idle(1);
      tag = "R7";
      op(1'b0, 1'b0, '0, '0, '0, 4'b0001);
      idle(1);
      op(1'b1, 1'b1, 12'h00C, 32'h1, '0, 4'b1000);
      idle(1);
      op(1'b1, 1'b1, 12'h004, 32'h1, '0, 4'b0010);
      op(1'b0, 1'b0, '0, '0, '0, 4'b1111);
      idle(1);
      tag = "R8";
      wr_op(12'h004, 32'h1);
      op(1'b0, 1'b0, '0, '0, 4'b1111, '0);
      op(1'b0, 1'b0, '0, '0, 4'b1111, '0);
      rd_op(12'h004);
      idle(1);
      tag = "R9";
      wr_op(12'h005, 32'h1);
      wr_op(12'h00A, 32'h1);
      wr_op(12'h010, 32'h1);
      wr_op(12'hFFC, 32'h1);
      wr_op(12'h006, 32'h0);
      rd_op(12'h005);
      rd_op(12'h010);
      rd_op(12'h013);
      idle(1);
      tag = "R10";
      rd_op(12'h00C);
      rd_op(12'h004);
      wr_op(12'h00C, 32'h0);
      rd_op(12'h00C);
      idle(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule